// File: doc/BRIEF.md
# Voting Session Phase Sequencer

This block runs the phase sequence of a vote for the presiding terminal. It drives three enables: one that opens the accreditation window, one that opens the voting window and one that starts collation. A session always moves from accreditation to voting to collation and then returns to idle.

Two control modes share that fixed order. In manual mode the presiding operator starts each phase with its own button. A press that does not belong to the next pending phase is dropped. In automatic mode an internal free-running tick starts each pending phase and the operator buttons are locked out. The accreditation and voting windows are timed in clock cycles, and the cycle counts are parameters. Collation stays enabled until the collation logic reports completion.

Top module: `vote_phase_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all three enables are low and the sequencer is idle.
- R2: At most one of en_accredit, en_vote and en_collate is high in any cycle.
- R3: Phases only ever start in the order accreditation, voting, collation. Voting starts only after an accreditation window has ended. Collation starts only after a voting window has ended.
- R4: In manual mode, a phase starts on a press of its own button. A press is a cycle in which the button is high after being low in the previous cycle. The phase enable is high from the cycle that follows the press.
- R5: In manual mode, a press of any button other than the one for the next pending phase has no effect. This covers a press while that phase or a later phase is active, and vote or collate presses while idle.
- R6: In automatic mode, each pending phase starts on the internal tick, and all three buttons are ignored. The tick fires once every TICK_CYCLES cycles, first on the TICK_CYCLES-th clock edge after reset is released.
- R7: en_accredit stays high for exactly ACC_CYCLES consecutive cycles.
- R8: en_vote stays high for exactly VOTE_CYCLES consecutive cycles.
- R9: en_collate stays high until collate_done is sampled high, and falls in the next cycle. collate_done has no effect in any other phase.
- R10: After collation ends, the sequencer is idle. A new session starts only on an accredit press in manual mode, or on a tick in automatic mode.
- R11: The mode input is sampled every cycle. The mode that is current when a pending phase would start decides whether a press or the tick starts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | 1 selects automatic mode, 0 selects manual mode |
| btn_accredit | input | 1 | Manual button that starts accreditation |
| btn_vote | input | 1 | Manual button that starts voting |
| btn_collate | input | 1 | Manual button that starts collation |
| collate_done | input | 1 | Completion signal from the collation logic |
| en_accredit | output | 1 | Accreditation window enable |
| en_vote | output | 1 | Voting window enable |
| en_collate | output | 1 | Collation enable |

## Verification
A wrong phase register shows at the enable outputs in the very next cycle, because the enables decode the phase directly. It appears as a skipped phase, two enables high together, or an enable that rises without its press or tick. A window timer that is off by one shows only when the enable falls, so the length of each window is measured from rise to fall. A tick counter that is out of phase shows only in automatic mode, at the next pending phase start. For that reason the bench compares every cycle against its own model across long runs that switch between the two modes.

// File: rtl/vsq_pkg.sv
package vsq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE         = 3'd0,
      PH_ACCREDIT     = 3'd1,
      PH_WAIT_VOTE    = 3'd2,
      PH_VOTE         = 3'd3,
      PH_WAIT_COLLATE = 3'd4,
      PH_COLLATE      = 3'd5
   } phase_e;

   localparam int N_BUTTONS = 3;
   localparam int BTN_ACC   = 0;
   localparam int BTN_VOTE  = 1;
   localparam int BTN_COLL  = 2;

endpackage

// File: rtl/vsq_tick_gen.sv
module vsq_tick_gen #(
   parameter int PERIOD = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = $clog2(PERIOD);
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   if (PERIOD < 2) begin : g_bad_period
      $error("vsq_tick_gen: PERIOD must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);

   // R6: the tick is a single-cycle pulse
   a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/vsq_press_detect.sv
module vsq_press_detect #(
   parameter int N          = 3,
   parameter bit EDGE_PRESS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] btn,
   output logic [N-1:0] press
);
   if (N < 1) begin : g_bad_n
      $error("vsq_press_detect: N must be at least 1");
   end

   if (EDGE_PRESS) begin : g_edge
      logic [N-1:0] btn_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) btn_q <= '0;
         else        btn_q <= btn;
      end
      assign press = btn & ~btn_q;

      // R4: a held button yields one press only
      a_r4_press_once: assert property (@(posedge clk) disable iff (!rst_n)
         (press != '0) |=> ((press & $past(press)) == '0));
   end else begin : g_level
      assign press = btn;
   end
endmodule

// File: rtl/vsq_window_timer.sv
module vsq_window_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   if (W < 1) begin : g_bad_w
      $error("vsq_window_timer: W must be at least 1");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R7, R8: a running count only moves down by one per cycle
   a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/vote_phase_seq.sv
module vote_phase_seq
   import vsq_pkg::*;
#(
   parameter int ACC_CYCLES  = 750_000_000,
   parameter int VOTE_CYCLES = 750_000_000,
   parameter int TICK_CYCLES = 25_000_000,
   parameter bit EDGE_PRESS  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_mode,
   input  logic btn_accredit,
   input  logic btn_vote,
   input  logic btn_collate,
   input  logic collate_done,
   output logic en_accredit,
   output logic en_vote,
   output logic en_collate
);
   localparam int MAX_WIN = (ACC_CYCLES > VOTE_CYCLES) ? ACC_CYCLES : VOTE_CYCLES;
   localparam int TMR_W   = $clog2(MAX_WIN + 1);
   localparam logic [TMR_W-1:0] ACC_LOAD  = TMR_W'(ACC_CYCLES - 1);
   localparam logic [TMR_W-1:0] VOTE_LOAD = TMR_W'(VOTE_CYCLES - 1);

   if (ACC_CYCLES < 1 || VOTE_CYCLES < 1) begin : g_bad_window
      $error("vote_phase_seq: window lengths must be at least 1 cycle");
   end
   if (TICK_CYCLES < 2) begin : g_bad_tick
      $error("vote_phase_seq: TICK_CYCLES must be at least 2");
   end

   logic                 tick;
   logic [N_BUTTONS-1:0] btn, press;
   logic                 tmr_load, tmr_expired;
   logic [TMR_W-1:0]     tmr_val;
   logic                 go_acc, go_vote, go_coll;
   phase_e               phase, phase_nx;

   assign btn[BTN_ACC]  = btn_accredit;
   assign btn[BTN_VOTE] = btn_vote;
   assign btn[BTN_COLL] = btn_collate;

   vsq_tick_gen #(.PERIOD(TICK_CYCLES)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   vsq_press_detect #(.N(N_BUTTONS), .EDGE_PRESS(EDGE_PRESS)) u_press (
      .clk(clk), .rst_n(rst_n), .btn(btn), .press(press));

   vsq_window_timer #(.W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .expired(tmr_expired));

   assign go_acc  = auto_mode ? tick : press[BTN_ACC];
   assign go_vote = auto_mode ? tick : press[BTN_VOTE];
   assign go_coll = auto_mode ? tick : press[BTN_COLL];

   always_comb begin
      phase_nx = phase;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (phase)
         PH_IDLE: if (go_acc) begin
            phase_nx = PH_ACCREDIT;
            tmr_load = 1'b1;
            tmr_val  = ACC_LOAD;
         end
         PH_ACCREDIT:     if (tmr_expired) phase_nx = PH_WAIT_VOTE;
         PH_WAIT_VOTE: if (go_vote) begin
            phase_nx = PH_VOTE;
            tmr_load = 1'b1;
            tmr_val  = VOTE_LOAD;
         end
         PH_VOTE:         if (tmr_expired) phase_nx = PH_WAIT_COLLATE;
         PH_WAIT_COLLATE: if (go_coll) phase_nx = PH_COLLATE;
         PH_COLLATE:      if (collate_done) phase_nx = PH_IDLE;
         default:         phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= phase_nx;
   end

   assign en_accredit = (phase == PH_ACCREDIT);
   assign en_vote     = (phase == PH_VOTE);
   assign en_collate  = (phase == PH_COLLATE);

   a_r2_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({en_accredit, en_vote, en_collate}));

   a_r3_vote_after_acc: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_vote) |-> $past(phase) == PH_WAIT_VOTE);

   a_r3_coll_after_vote: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_collate) |-> $past(phase) == PH_WAIT_COLLATE);

   a_r4_manual_press: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(en_accredit) && $past(!auto_mode)) |-> $past(press[BTN_ACC]));

   a_r6_auto_tick: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(en_vote) && $past(auto_mode)) |-> $past(tick));

   a_r7_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en_accredit && !tmr_expired) |=> en_accredit);

   a_r7_acc_end: assert property (@(posedge clk) disable iff (!rst_n)
      (en_accredit && tmr_expired) |=> !en_accredit);

   a_r8_vote_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en_vote && !tmr_expired) |=> en_vote);

   a_r9_coll_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en_collate && !collate_done) |=> en_collate);

   a_r10_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (en_collate && collate_done) |=> (phase == PH_IDLE));
endmodule

// File: tb/vote_phase_seq_bench.sv
module vote_phase_seq_bench;
   localparam int ACC = 12;
   localparam int VOT = 9;
   localparam int TCK = 5;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0;
   logic auto_mode = 1'b0, b_acc = 1'b0, b_vote = 1'b0, b_coll = 1'b0, done = 1'b0;
   logic en_a, en_v, en_c;

   vote_phase_seq #(.ACC_CYCLES(ACC), .VOTE_CYCLES(VOT), .TICK_CYCLES(TCK)) u_vote_phase_seq (
      .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode),
      .btn_accredit(b_acc), .btn_vote(b_vote), .btn_collate(b_coll),
      .collate_done(done), .en_accredit(en_a), .en_vote(en_v), .en_collate(en_c));

   int n_chk = 0, n_err = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // reference model built from the requirements
   int m_st = 0, m_tmr = 0, m_tck = 0;
   bit m_pa = 0, m_pv = 0, m_pc = 0;

   function automatic int exp_en(input int st);
      return (st == 1) ? 1 : (st == 3) ? 2 : (st == 5) ? 4 : 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_tmr = 0; m_tck = 0; m_pa = 0; m_pv = 0; m_pc = 0;
      end else begin
         bit tk, ga, gv, gc;
         tk = (m_tck == TCK - 1);
         ga = auto_mode ? tk : (b_acc && !m_pa);
         gv = auto_mode ? tk : (b_vote && !m_pv);
         gc = auto_mode ? tk : (b_coll && !m_pc);
         m_tck = tk ? 0 : m_tck + 1;
         m_pa = b_acc; m_pv = b_vote; m_pc = b_coll;
         case (m_st)
            0: if (ga) begin m_st = 1; m_tmr = ACC - 1; end
            1: if (m_tmr == 0) m_st = 2; else m_tmr--;
            2: if (gv) begin m_st = 3; m_tmr = VOT - 1; end
            3: if (m_tmr == 0) m_st = 4; else m_tmr--;
            4: if (gc) m_st = 5;
            default: if (done) m_st = 0;
         endcase
      end
   end

   // every-cycle comparison against the model (R2, R3, R11)
   always @(negedge clk) begin
      int act;
      act = {29'd0, en_c, en_v, en_a};
      chk(act == exp_en(m_st), "R2 R3 R11 model", act, exp_en(m_st));
   end

   task automatic press(ref logic b);
      @(negedge clk) b = 1'b1;
      @(negedge clk) b = 1'b0;
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int n;
      void'($urandom(32'd4242));
      // R1: reset
      idle_cycles(3);
      chk({en_a, en_v, en_c} == 3'b000, "R1 during reset", {en_a, en_v, en_c}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({en_a, en_v, en_c} == 3'b000, "R1 after reset", {en_a, en_v, en_c}, 0);

      // manual session with out-of-order presses
      press(b_vote); press(b_coll); idle_cycles(2);
      chk({en_a, en_v, en_c} == 3'b000, "R5 idle vote/collate press", {en_a, en_v, en_c}, 0);
      press(b_acc);
      chk(en_a == 1'b1, "R4 accredit starts on press", en_a, 1);
      n = 0;
      while (en_a) begin
         n++;
         if (n == 3) begin b_acc = 1'b1; b_vote = 1'b1; end
         if (n == 4) begin b_acc = 1'b0; b_vote = 1'b0; end
         @(negedge clk);
      end
      chk(n == ACC, "R7 accredit window length (R5 presses inside)", n, ACC);
      press(b_coll); press(b_acc); idle_cycles(2);
      chk({en_a, en_v, en_c} == 3'b000, "R5 wrong press while waiting for vote", {en_a, en_v, en_c}, 0);
      press(b_vote);
      n = 0;
      while (en_v) begin n++; @(negedge clk); end
      chk(n == VOT, "R8 vote window length", n, VOT);
      press(b_coll);
      chk(en_c == 1'b1, "R4 collate starts on press", en_c, 1);
      idle_cycles(20);
      chk(en_c == 1'b1, "R9 collate held without done", en_c, 1);
      done = 1'b1; @(negedge clk); done = 1'b0;
      chk(en_c == 1'b0, "R9 collate falls after done", en_c, 0);
      press(b_vote); press(b_coll); done = 1'b1; idle_cycles(3); done = 1'b0;
      chk({en_a, en_v, en_c} == 3'b000, "R10 idle after collation (R9 stray done)", {en_a, en_v, en_c}, 0);

      // automatic mode with buttons hammered
      auto_mode = 1'b1;
      n = 0;
      while (!en_a && n < 4 * TCK) begin
         b_acc = ~b_acc; b_vote = ~b_vote; b_coll = ~b_coll;
         n++; @(negedge clk);
      end
      chk(en_a == 1'b1, "R6 accredit starts from tick", en_a, 1);
      n = 0;
      while (!en_c && n < 200) begin
         b_acc = ~b_acc; b_vote = ~b_vote; b_coll = ~b_coll;
         n++; @(negedge clk);
      end
      chk(en_c == 1'b1, "R6 automatic run reaches collation", en_c, 1);
      b_acc = 0; b_vote = 0; b_coll = 0;
      done = 1'b1; @(negedge clk); done = 1'b0;
      chk(en_c == 1'b0, "R10 automatic collation ends", en_c, 0);

      // random mix, checked by the model every cycle (R11 mode changes)
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if ($urandom_range(299) == 0) auto_mode = ~auto_mode;
         b_acc  = ($urandom_range(9) == 0);
         b_vote = ($urandom_range(9) == 0);
         b_coll = ($urandom_range(9) == 0);
         done   = ($urandom_range(14) == 0);
      end
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule